// File: doc/BRIEF.md
# Frame-Based Expression Stack Controller

This block keeps operands in a chain of small fixed-size frames, eight words each, instead of one flat stack. Opening a frame allocates an empty one on top of the chain. Operands are pushed into the open frame. An operator consumes the open frame as a whole, releases it, and drops its single result into the frame underneath. Each data frame has a companion link record with four fields:

- a saved program counter;
- a fill level, which serves as the low bits of a stack pointer whose high bits are the frame index;
- a link to the frame below (the sender);
- the current frame of the enclosing context (the lexical link).

Two indices describe the chain at any moment. The open index names the top frame, where pushes land. The current index names the base frame of the running context. A send turns the open frame into the base of a new context and stores the caller's program counter in the link record of the frame below. A return releases the context's base frame, delivers one result value into the caller's top frame and hands back the saved program counter.

Frames are held in on-chip registers. Frame 0 is the permanent root. Every other frame is taken from a free mask, lowest index first, and returned to the mask when it is released. Any operation that cannot complete leaves the whole state untouched and raises a one-cycle fault pulse.

Top module: `fsc_frame_stack`

## Requirements
- R1: After reset the open and current indices are both 0, the open frame holds no words, `top_o` is 0, `fault_o` is 0 and `ret_pc_o` is 0.
- R2: Opcode 1 (open) claims the lowest-numbered free frame, makes it the open frame with zero words, and leaves the current index unchanged.
- R3: Opcode 2 (push) appends the operand to the open frame: the word count rises by one and `top_o` shows the operand.
- R4: A push into an open frame that already holds FRAME_WORDS words is rejected, and an open when no frame is free is rejected.
- R5: Opcodes 3, 4 and 5 (add, subtract, multiply) compute word0+word1, word0-word1 or word0*word1 of the open frame, modulo 2^WORD_W. Word0 is the first word pushed. The open frame is released, its sender becomes the open frame, and the result is appended to it.
- R6: An operator is rejected when the open frame holds fewer than two words, when the open frame is the current frame, or when the frame below is full.
- R7: Opcode 6 (send) makes the current index equal to the open index and stores the low PC_W bits of the operand as the saved PC of the frame below. It is rejected when open equals current.
- R8: Opcode 7 (return) requires open equal to current and current not 0. It releases that frame and appends the operand to its sender, which becomes the open frame. The current index reverts to the context that was current when the released frame was opened, and `ret_pc_o` shows the PC saved in the new open frame. The return is rejected otherwise, or when the target frame is full.
- R9: Opcode 0, or `op_valid_i` low, changes nothing visible and leaves `fault_o` low. `ret_pc_o` changes only on an accepted return.
- R10: `fault_o` is high for exactly the cycle after a rejected operation, and a rejected operation leaves indices, word count and top word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (0 nop, 1 open, 2 push, 3 add, 4 sub, 5 mul, 6 send, 7 return) |
| operand_i | input | WORD_W | Value pushed, result returned, or PC saved on send |
| top_o | output | WORD_W | Most recently pushed word of the open frame, 0 if it is empty |
| o_cnt_o | output | $clog2(FRAME_WORDS+1) | Words held by the open frame |
| o_idx_o | output | $clog2(FRAMES) | Open frame index |
| c_idx_o | output | $clog2(FRAMES) | Current frame index |
| ret_pc_o | output | PC_W | PC delivered by the last accepted return |
| fault_o | output | 1 | One-cycle pulse after a rejected operation |

## Verification
The bench builds the block with FRAMES=4, WORD_W=16 and PC_W=8. With four frames, three nested opens exhaust the pool, so the no-free-frame rejection is reached in a short run. The 16-bit word makes multiplication and subtraction wrap at a width that is easy to predict. A fill of eight words in one opened frame reaches the full-frame rejection. Nested sends two deep exercise the restoring of the current index and the order in which saved PCs come back.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_OPEN = 3'd1,
        OP_PUSH = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_MUL  = 3'd5,
        OP_SEND = 3'd6,
        OP_RET  = 3'd7
    } fsc_op_e;

endpackage

// File: rtl/fsc_alloc.sv
module fsc_alloc #(
    parameter int FRAMES = 8,
    localparam int IW = $clog2(FRAMES)
) (
    input  logic [FRAMES-1:0] busy_i,
    output logic [IW-1:0]     idx_o,
    output logic              any_o
);
    // Lowest-index free frame wins: scan from the top down so the last hit stands.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = FRAMES - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                idx_o = IW'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsc_alu.sv
module fsc_alu #(
    parameter int WORD_W = 32
) (
    input  fsc_pkg::fsc_op_e  op_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] y_o
);
    import fsc_pkg::*;

    always_comb begin
        unique case (op_i)
            OP_SUB:  y_o = a_i - b_i;
            OP_MUL:  y_o = a_i * b_i;
            default: y_o = a_i + b_i;
        endcase
    end
endmodule

// File: rtl/fsc_frame_stack.sv
module fsc_frame_stack #(
    parameter int WORD_W      = 32,
    parameter int FRAMES      = 8,
    parameter int FRAME_WORDS = 8,
    parameter int PC_W        = 16,
    localparam int IW  = $clog2(FRAMES),
    localparam int CW  = $clog2(FRAME_WORDS + 1),
    localparam int FIW = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [2:0]        op_i,
    input  logic [WORD_W-1:0] operand_i,
    output logic [WORD_W-1:0] top_o,
    output logic [CW-1:0]     o_cnt_o,
    output logic [IW-1:0]     o_idx_o,
    output logic [IW-1:0]     c_idx_o,
    output logic [PC_W-1:0]   ret_pc_o,
    output logic              fault_o
);
    import fsc_pkg::*;

    localparam logic [CW-1:0] FULL_CNT = CW'(FRAME_WORDS);
    localparam logic [CW-1:0] TWO_CNT  = CW'(2);

    // Data words plus the four-part link record of every frame
    // (saved pc, fill level, sender link, lexical link).
    typedef struct packed {
        logic [FRAMES-1:0][FRAME_WORDS-1:0][WORD_W-1:0] data;
        logic [FRAMES-1:0][CW-1:0]                      fill;
        logic [FRAMES-1:0][PC_W-1:0]                    pc;
        logic [FRAMES-1:0][IW-1:0]                      sender;
        logic [FRAMES-1:0][IW-1:0]                      lexical;
        logic [FRAMES-1:0]                              busy;
        logic [IW-1:0]                                  o;
        logic [IW-1:0]                                  c;
        logic [PC_W-1:0]                                rpc;
        logic                                           fault;
    } state_t;

    state_t s_q, s_d;

    fsc_op_e          op;
    logic [IW-1:0]    free_idx;
    logic             free_any;
    logic [IW-1:0]    below;
    logic [CW-1:0]    o_fill;
    logic [CW-1:0]    b_fill;
    logic [WORD_W-1:0] alu_y;

    assign op     = op_valid_i ? fsc_op_e'(op_i) : OP_NOP;
    assign below  = s_q.sender[s_q.o];
    assign o_fill = s_q.fill[s_q.o];
    assign b_fill = s_q.fill[below];

    fsc_alloc #(.FRAMES(FRAMES)) u_alloc (
        .busy_i (s_q.busy),
        .idx_o  (free_idx),
        .any_o  (free_any)
    );

    fsc_alu #(.WORD_W(WORD_W)) u_alu (
        .op_i (op),
        .a_i  (s_q.data[s_q.o][0]),
        .b_i  (s_q.data[s_q.o][1]),
        .y_o  (alu_y)
    );

    always_comb begin
        s_d       = s_q;
        s_d.fault = 1'b0;
        unique case (op)
            OP_OPEN: begin
                if (!free_any) begin
                    s_d.fault = 1'b1;
                end else begin
                    s_d.busy[free_idx]    = 1'b1;
                    s_d.fill[free_idx]    = '0;
                    s_d.pc[free_idx]      = '0;
                    s_d.sender[free_idx]  = s_q.o;
                    s_d.lexical[free_idx] = s_q.c;
                    s_d.o                 = free_idx;
                end
            end
            OP_PUSH: begin
                if (o_fill == FULL_CNT) begin
                    s_d.fault = 1'b1;
                end else begin
                    s_d.data[s_q.o][o_fill[FIW-1:0]] = operand_i;
                    s_d.fill[s_q.o]                  = o_fill + CW'(1);
                end
            end
            OP_ADD, OP_SUB, OP_MUL: begin
                if (o_fill < TWO_CNT || s_q.o == s_q.c || b_fill == FULL_CNT) begin
                    s_d.fault = 1'b1;
                end else begin
                    s_d.data[below][b_fill[FIW-1:0]] = alu_y;
                    s_d.fill[below]                  = b_fill + CW'(1);
                    s_d.busy[s_q.o]                  = 1'b0;
                    s_d.o                            = below;
                end
            end
            OP_SEND: begin
                if (s_q.o == s_q.c) begin
                    s_d.fault = 1'b1;
                end else begin
                    s_d.pc[below] = operand_i[PC_W-1:0];
                    s_d.c         = s_q.o;
                end
            end
            OP_RET: begin
                if (s_q.o != s_q.c || s_q.c == '0 || b_fill == FULL_CNT) begin
                    s_d.fault = 1'b1;
                end else begin
                    s_d.data[below][b_fill[FIW-1:0]] = operand_i;
                    s_d.fill[below]                  = b_fill + CW'(1);
                    s_d.busy[s_q.c]                  = 1'b0;
                    s_d.o                            = below;
                    s_d.c                            = s_q.lexical[s_q.c];
                    s_d.rpc                          = s_q.pc[below];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.busy <= FRAMES'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign o_cnt_o  = o_fill;
    assign top_o    = (o_fill == '0) ? '0 : s_q.data[s_q.o][FIW'(o_fill - CW'(1))];
    assign o_idx_o  = s_q.o;
    assign c_idx_o  = s_q.c;
    assign ret_pc_o = s_q.rpc;
    assign fault_o  = s_q.fault;

endmodule

// File: rtl/fsc_frame_stack_chk.sv
module fsc_frame_stack_chk #(
    parameter int WORD_W      = 32,
    parameter int FRAMES      = 8,
    parameter int FRAME_WORDS = 8,
    parameter int PC_W        = 16,
    localparam int IW = $clog2(FRAMES),
    localparam int CW = $clog2(FRAME_WORDS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid_i,
    input logic [2:0]        op_i,
    input logic [WORD_W-1:0] operand_i,
    input logic [WORD_W-1:0] top_o,
    input logic [CW-1:0]     o_cnt_o,
    input logic [IW-1:0]     o_idx_o,
    input logic [IW-1:0]     c_idx_o,
    input logic [PC_W-1:0]   ret_pc_o,
    input logic              fault_o
);
    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_cnt_o <= CW'(FRAME_WORDS));

    // R2
    open_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == 3'd1) |=>
            (fault_o || (o_cnt_o == '0 && $stable(c_idx_o))));

    // R3
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == 3'd2) |=>
            (fault_o || (o_cnt_o == $past(o_cnt_o) + CW'(1)
                         && top_o == $past(operand_i) && $stable(o_idx_o))));

    // R7
    send_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == 3'd6) |=>
            (fault_o || (c_idx_o == $past(o_idx_o) && $stable(o_idx_o))));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid_i || op_i == 3'd0) |=>
            (!fault_o && $stable(o_idx_o) && $stable(c_idx_o)
             && $stable(o_cnt_o) && $stable(top_o)));

    // R9
    rpc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid_i && op_i == 3'd7) |=> $stable(ret_pc_o));

    // R10
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i != 3'd0) |=>
            (!fault_o || ($stable(o_idx_o) && $stable(c_idx_o)
                          && $stable(o_cnt_o) && $stable(top_o))));

endmodule

bind fsc_frame_stack fsc_frame_stack_chk #(
    .WORD_W(WORD_W), .FRAMES(FRAMES), .FRAME_WORDS(FRAME_WORDS), .PC_W(PC_W)
) u_chk (.*);

// File: tb/fsc_frame_stack_test.sv
module fsc_frame_stack_test;
    localparam int W  = 16;
    localparam int NF = 4;
    localparam int FW = 8;
    localparam int PW = 8;
    localparam int IW = $clog2(NF);
    localparam int CW = $clog2(FW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid_i = 1'b0;
    logic [2:0]    op_i = '0;
    logic [W-1:0]  operand_i = '0;
    logic [W-1:0]  top_o;
    logic [CW-1:0] o_cnt_o;
    logic [IW-1:0] o_idx_o, c_idx_o;
    logic [PW-1:0] ret_pc_o;
    logic          fault_o;

    fsc_frame_stack #(.WORD_W(W), .FRAMES(NF), .FRAME_WORDS(FW), .PC_W(PW)) uut (.*);

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [W-1:0]  top;
        logic [CW-1:0] cnt;
        logic [IW-1:0] o;
        logic [IW-1:0] c;
        logic [PW-1:0] rpc;
        logic          flt;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    // Reference model of the frame chain
    logic [W-1:0]  md[NF][FW];
    int            mcnt[NF], msnd[NF], mlex[NF];
    logic [PW-1:0] mpc[NF];
    bit            mbusy[NF];
    int            mo, mc;
    logic [PW-1:0] mrpc;
    bit            mflt;

    task automatic check(input bit ok, input string tag, input string act, input string expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%s expected=%s", tag, act, expv);
        end
    endtask

    function automatic exp_t model_out();
        exp_t e;
        e.top = (mcnt[mo] == 0) ? '0 : md[mo][mcnt[mo]-1];
        e.cnt = CW'(mcnt[mo]);
        e.o   = IW'(mo);
        e.c   = IW'(mc);
        e.rpc = mrpc;
        e.flt = mflt;
        return e;
    endfunction

    task automatic model_step(input int op, input logic [W-1:0] v);
        int b, n;
        logic [W-1:0] r;
        mflt = 1'b0;
        b = msnd[mo];
        case (op)
            1: begin
                n = -1;
                for (int i = NF - 1; i >= 0; i--) if (!mbusy[i]) n = i;
                if (n < 0) mflt = 1'b1;
                else begin
                    mbusy[n] = 1'b1; mcnt[n] = 0; mpc[n] = '0;
                    msnd[n] = mo; mlex[n] = mc; mo = n;
                end
            end
            2: if (mcnt[mo] == FW) mflt = 1'b1;
               else begin md[mo][mcnt[mo]] = v; mcnt[mo]++; end
            3, 4, 5: begin
                if (mcnt[mo] < 2 || mo == mc || mcnt[b] == FW) mflt = 1'b1;
                else begin
                    r = (op == 3) ? md[mo][0] + md[mo][1] :
                        (op == 4) ? md[mo][0] - md[mo][1] : md[mo][0] * md[mo][1];
                    md[b][mcnt[b]] = r; mcnt[b]++; mbusy[mo] = 1'b0; mo = b;
                end
            end
            6: if (mo == mc) mflt = 1'b1;
               else begin mpc[b] = v[PW-1:0]; mc = mo; end
            7: begin
                if (mo != mc || mc == 0 || mcnt[b] == FW) mflt = 1'b1;
                else begin
                    md[b][mcnt[b]] = v; mcnt[b]++; mbusy[mc] = 1'b0;
                    mo = b; mc = mlex[mc]; mrpc = mpc[b];
                end
            end
            default: ;
        endcase
    endtask

    // Driver: applies one operation and queues what the model expects after it.
    task automatic do_op(input int op, input int val, input string tag);
        @(negedge clk);
        op_valid_i = 1'b1;
        op_i       = 3'(op);
        operand_i  = W'(val);
        model_step(op, W'(val));
        @(posedge clk);
        exp_q.push_back(model_out());
        tag_q.push_back(tag);
    endtask

    // Monitor: compares each queued expectation half a cycle after its edge.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = '{top: top_o, cnt: o_cnt_o, o: o_idx_o, c: c_idx_o,
                      rpc: ret_pc_o, flt: fault_o};
                check(a == e, t,
                      $sformatf("top=%0d cnt=%0d o=%0d c=%0d pc=%0h flt=%0b",
                                a.top, a.cnt, a.o, a.c, a.rpc, a.flt),
                      $sformatf("top=%0d cnt=%0d o=%0d c=%0d pc=%0h flt=%0b",
                                e.top, e.cnt, e.o, e.c, e.rpc, e.flt));
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) begin
            mcnt[i] = 0; msnd[i] = 0; mlex[i] = 0; mpc[i] = '0; mbusy[i] = (i == 0);
            for (int j = 0; j < FW; j++) md[i][j] = '0;
        end
        mo = 0; mc = 0; mrpc = '0; mflt = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(o_idx_o == 0 && c_idx_o == 0 && o_cnt_o == 0 && top_o == 0
              && fault_o == 0 && ret_pc_o == 0, "R1 reset",
              $sformatf("o=%0d c=%0d cnt=%0d", o_idx_o, c_idx_o, o_cnt_o), "o=0 c=0 cnt=0");

        // ((3+4)*5)
        do_op(1, 0, "R2 open");
        do_op(1, 0, "R2 open nested");
        do_op(2, 3, "R3 push");
        do_op(2, 4, "R3 push");
        do_op(3, 0, "R5 add");
        do_op(2, 5, "R3 push");
        do_op(5, 0, "R5 mul");
        @(negedge clk);
        check(top_o == 16'd35 && o_idx_o == 0, "R5 nested result",
              $sformatf("%0d", top_o), "35");

        // wrapping subtract and multiply
        do_op(1, 0, "R2 open");
        do_op(2, 3, "R3 push");
        do_op(2, 10, "R3 push");
        do_op(4, 0, "R5 sub wraps");
        do_op(1, 0, "R2 open");
        do_op(2, 300, "R3 push");
        do_op(2, 300, "R3 push");
        do_op(5, 0, "R5 mul wraps");

        // operator faults
        do_op(3, 0, "R6 op at context base");
        do_op(1, 0, "R2 open");
        do_op(2, 1, "R3 push");
        do_op(3, 0, "R6 op with one word");
        do_op(2, 2, "R3 push");
        do_op(3, 0, "R5 add");

        // full frame
        do_op(1, 0, "R2 open");
        for (int i = 0; i < FW; i++) do_op(2, i + 20, "R3 fill");
        do_op(2, 99, "R4 push into full frame");
        do_op(4, 0, "R5 sub from full frame");

        // exhaustion: root plus three opens uses all four frames
        do_op(1, 0, "R2 open");
        do_op(1, 0, "R2 open");
        do_op(1, 0, "R2 open");
        do_op(1, 0, "R4 open with none free");
        do_op(0, 0, "R9 nop");
        do_op(2, 1, "R3 push");
        do_op(2, 1, "R3 push");
        do_op(3, 0, "R5 add");
        do_op(2, 1, "R3 push");
        do_op(3, 0, "R5 add");
        do_op(2, 1, "R3 push");
        do_op(3, 0, "R5 add");

        // context switch faults at root
        do_op(6, 8'h11, "R7 send with open equal current");
        do_op(7, 5, "R8 return at root");

        // single send/return with work inside the context
        do_op(1, 0, "R2 open");
        do_op(6, 8'h55, "R7 send");
        do_op(1, 0, "R2 open in callee");
        do_op(7, 1, "R8 return with open above current");
        do_op(2, 6, "R3 push");
        do_op(2, 7, "R3 push");
        do_op(5, 0, "R5 mul into callee base");
        do_op(7, 42, "R8 return");

        // two nested contexts: PCs come back innermost first
        do_op(1, 0, "R2 open");
        do_op(6, 8'hA1, "R7 send outer");
        do_op(1, 0, "R2 open");
        do_op(6, 8'hB2, "R7 send inner");
        do_op(7, 9, "R8 return inner");
        do_op(7, 8, "R8 return outer");
        do_op(7, 1, "R8 return at root again");

        // idle with op_valid low
        @(negedge clk);
        op_valid_i = 1'b0;
        op_i       = 3'd2;
        operand_i  = 16'h7777;
        @(posedge clk);
        mflt = 1'b0;
        exp_q.push_back(model_out());
        tag_q.push_back("R9 valid low ignored");
        @(negedge clk);
        op_valid_i = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule